// File: doc/BRIEF.md
# Long Write Packet Payload Packer

This block turns one display-link write command into the words that a link transmitter consumes. A command carries an 8-bit data identifier and a 16-bit value. For long writes the value is a byte count, and the block pulls that many bytes from a valid/ready byte stream. It packs the bytes into 32-bit payload words and pushes them to a payload FIFO port. After the last payload word it pushes one 32-bit header word to a header FIFO port. It then waits for a FIFO-empty event from the transmitter and ends with either a one-cycle completion pulse or a one-cycle timeout pulse.

Short writes consume no bytes. For these the 16-bit value holds two parameter bytes, and the block sends only the header, then reports completion as soon as the header is accepted. Only one command is in flight at a time: the command port is ready only while the block is idle. Lane serialisation and error-code generation belong to later stages.

Top module: `pkt_payload_packer`

## Requirements
- R1: Payload bytes are packed little-endian: the byte taken k-th within a word (k = 0..3) lands on bits [8k+7:8k] of that payload word.
- R2: A long write of N bytes produces max(1, ceil(N/4)) payload words. A final word holding 1, 2 or 3 bytes has zero in its unused upper bytes, and N = 0 produces one all-zero word without taking any byte.
- R3: The header word is presented only after the last payload word has been accepted, never alongside a payload word. Its layout is bits [7:0] = identifier, [15:8] = value bits [7:0], [23:16] = value bits [15:8], [31:24] = zero.
- R4: An identifier whose low six bits equal 0x29 or 0x39 selects the long path (the top two bits pass through unchanged). Any other identifier is a short write: one header word in the R3 layout, no payload word, and the byte input stays not-ready.
- R5: After a long write's header is accepted, a FIFO-empty event seen in the waiting state raises the completion pulse in the next cycle. FIFO-empty asserted before the header is accepted is ignored.
- R6: If no FIFO-empty event arrives in the TIMEOUT_CYCLES cycles after the header handshake edge, the timeout pulse rises in the cycle after the TIMEOUT_CYCLES-th such edge. An event on that last edge still counts as completion.
- R7: A short write raises the completion pulse in the cycle after its header handshake, with no wait for FIFO-empty.
- R8: Completion and timeout are single-cycle pulses and are never high together.
- R9: The command ready output is high only while idle. It drops in the cycle after a command is taken and returns with the completion or timeout pulse.
- R10: Under synchronous active-low reset, command ready is high and byte ready, both word valids, completion and timeout are low, whatever was in progress.
- R11: While a word port's valid is high and its ready is low, valid stays high and the word does not change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| cmd_valid | input | 1 | Command offered |
| cmd_ready | output | 1 | Block idle, command taken on this edge |
| cmd_id | input | 8 | Data identifier |
| cmd_word | input | 16 | Byte count (long) or two parameter bytes (short) |
| in_valid | input | 1 | Payload byte offered |
| in_ready | output | 1 | Payload byte taken on this edge |
| in_data | input | 8 | Payload byte |
| pl_valid | output | 1 | Payload word offered |
| pl_ready | input | 1 | Payload FIFO accepts the word |
| pl_data | output | 32 | Payload word |
| hd_valid | output | 1 | Header word offered |
| hd_ready | input | 1 | Header FIFO accepts the word |
| hd_data | output | 32 | Header word |
| fifo_empty | input | 1 | Transmitter FIFO-empty event |
| cmp_done | output | 1 | Completion pulse |
| cmp_timeout | output | 1 | Timeout pulse |

## Verification
A wrong byte lane or a stale accumulator shows on the next payload handshake as a wrong word, or as nonzero upper bytes in a partial word. A wrong remaining-byte count shows as one word too many or too few, and the header then appears early or late against the bench's word count. A wrong state or timer value shows within one cycle of the header handshake, or within TIMEOUT_CYCLES + 1 cycles of it, as a completion or timeout pulse in the wrong cycle. The same fault also shows as command ready returning at the wrong time.

// File: rtl/ppk_pkg.sv
// Shared constants, state type and helpers for the payload packer.
// Assumes the header format is fixed at 32 bits: id, two value bytes, zero pad.
package ppk_pkg;

    localparam int BYTE_W = 8;
    localparam int VAL_W  = 16;
    localparam int HDR_W  = 32;

    // Six-bit data types that carry a payload; bits [7:6] are a channel tag.
    localparam logic [5:0] DT_GEN_LONG = 6'h29;
    localparam logic [5:0] DT_CMD_LONG = 6'h39;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_PACK,
        ST_HDR,
        ST_WAIT
    } ppk_state_e;

    // True when the identifier selects the payload path.
    function automatic logic dt_is_long(input logic [BYTE_W-1:0] id);
        return (id[5:0] == DT_GEN_LONG) || (id[5:0] == DT_CMD_LONG);
    endfunction

    // Build the header word from identifier and 16-bit value.
    function automatic logic [HDR_W-1:0] make_header(input logic [BYTE_W-1:0] id,
                                                     input logic [VAL_W-1:0]  val);
        return {8'h00, val[15:8], val[7:0], id};
    endfunction

endpackage

// File: rtl/ppk_timer.sv
// Wait-window counter. Counts cycles while run is high and clears when run
// drops. Assumes LIMIT >= 1; expire is high on the LIMIT-th running edge.
module ppk_timer #(
    parameter int LIMIT = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run,
    output logic expire
);
    localparam int CW = $clog2(LIMIT + 1);

    logic [CW-1:0] cnt;

    // Count running cycles, clear otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) cnt <= '0;
        else                cnt <= cnt + 1'b1;
    end

    assign expire = run && (cnt == CW'(LIMIT - 1));

    // R6: the count never passes the window while running.
    p_cnt_bound_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (int'(cnt) < LIMIT));

endmodule

// File: rtl/ppk_packer.sv
// Byte-to-word packer. On start it loads the byte count, then accepts bytes
// little-endian into an accumulator and offers a word when it is full or the
// count runs out. A zero count yields one zero word. Assumes LANES >= 2 and
// that start only arrives while not busy.
module ppk_packer
    import ppk_pkg::*;
#(
    parameter int LANES = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    start,
    input  logic [VAL_W-1:0]        start_count,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [BYTE_W-1:0]       in_data,
    output logic                    out_valid,
    input  logic                    out_ready,
    output logic [LANES*BYTE_W-1:0] out_data,
    output logic                    last_taken
);
    localparam int WORD_W = LANES * BYTE_W;
    localparam int LANE_W = $clog2(LANES);

    logic              busy;
    logic              out_v;
    logic [WORD_W-1:0] acc;
    logic [LANE_W-1:0] lane;
    logic [VAL_W-1:0]  rem;
    logic              take_byte;
    logic              take_word;

    assign in_ready   = busy && !out_v && (rem != '0);
    assign take_byte  = in_ready && in_valid;
    assign take_word  = out_v && out_ready;
    assign out_valid  = out_v;
    assign out_data   = acc;
    assign last_taken = take_word && (rem == '0);

    // Load, fill lanes, and release words.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            out_v <= 1'b0;
            acc   <= '0;
            lane  <= '0;
            rem   <= '0;
        end else if (start) begin
            busy  <= 1'b1;
            out_v <= (start_count == '0);
            acc   <= '0;
            lane  <= '0;
            rem   <= start_count;
        end else begin
            if (take_byte) begin
                acc[int'(lane)*BYTE_W +: BYTE_W] <= in_data;
                rem  <= rem - 1'b1;
                lane <= lane + 1'b1;
                if (lane == LANE_W'(LANES - 1) || rem == VAL_W'(1)) out_v <= 1'b1;
            end
            if (take_word) begin
                out_v <= 1'b0;
                acc   <= '0;
                lane  <= '0;
                if (rem == '0) busy <= 1'b0;
            end
        end
    end

    // R2: a partial word has zero above its filled lanes.
    p_upper_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (out_v && lane != '0) |-> ((acc >> (int'(lane) * BYTE_W)) == '0));

    // R2: while busy and no word is pending, bytes remain to be taken.
    p_rem_live_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !out_v) |-> (rem != '0));

    // R11: a stalled payload word holds.
    p_word_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (out_v && !out_ready) |=> (out_v && $stable(acc)));

endmodule

// File: rtl/ppk_ctrl.sv
// Command sequencer: idle -> pack (long only) -> header -> wait (long only).
// Raises a one-cycle completion or timeout pulse when leaving the last state.
// Assumes the packer reports last_taken exactly once per long command.
module ppk_ctrl
    import ppk_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    output logic              cmd_ready,
    input  logic [BYTE_W-1:0] cmd_id,
    input  logic [VAL_W-1:0]  cmd_word,
    output logic              pack_start,
    input  logic              pack_last,
    output logic              hd_valid,
    input  logic              hd_ready,
    output logic [HDR_W-1:0]  hd_data,
    output logic              wait_run,
    input  logic              wait_expire,
    input  logic              fifo_empty,
    output logic              cmp_done,
    output logic              cmp_timeout
);
    ppk_state_e        state;
    logic [BYTE_W-1:0] id_q;
    logic [VAL_W-1:0]  val_q;
    logic              long_q;

    assign cmd_ready  = (state == ST_IDLE);
    assign pack_start = cmd_ready && cmd_valid && dt_is_long(cmd_id);
    assign hd_valid   = (state == ST_HDR);
    assign hd_data    = make_header(id_q, val_q);
    assign wait_run   = (state == ST_WAIT);

    // Step the command through its phases and emit end pulses.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            id_q        <= '0;
            val_q       <= '0;
            long_q      <= 1'b0;
            cmp_done    <= 1'b0;
            cmp_timeout <= 1'b0;
        end else begin
            cmp_done    <= 1'b0;
            cmp_timeout <= 1'b0;
            unique case (state)
                ST_IDLE: if (cmd_valid) begin
                    id_q   <= cmd_id;
                    val_q  <= cmd_word;
                    long_q <= dt_is_long(cmd_id);
                    state  <= dt_is_long(cmd_id) ? ST_PACK : ST_HDR;
                end
                ST_PACK: if (pack_last) state <= ST_HDR;
                ST_HDR: if (hd_ready) begin
                    if (long_q) begin
                        state <= ST_WAIT;
                    end else begin
                        cmp_done <= 1'b1;
                        state    <= ST_IDLE;
                    end
                end
                ST_WAIT: begin
                    if (fifo_empty) begin
                        cmp_done <= 1'b1;
                        state    <= ST_IDLE;
                    end else if (wait_expire) begin
                        cmp_timeout <= 1'b1;
                        state       <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    // R8: the two end pulses never coincide.
    p_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !(cmp_done && cmp_timeout));

    // R8: each end pulse lasts one cycle.
    p_pulse_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmp_done || cmp_timeout) |=> !(cmp_done || cmp_timeout));

    // R9: a taken command closes the command port next cycle.
    p_accept_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready) |=> !cmd_ready);

    // R5 / R7: completion follows a FIFO-empty wait or a short header handshake.
    p_done_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_done |-> ($past(wait_run && fifo_empty) ||
                      $past(hd_valid && hd_ready && !long_q)));

    // R6: timeout only follows an expired window with no FIFO-empty.
    p_timeout_cause_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmp_timeout |-> $past(wait_run && wait_expire && !fifo_empty));

    // R11: a stalled header holds.
    p_hdr_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (hd_valid && !hd_ready) |=> (hd_valid && $stable(hd_data)));

endmodule

// File: rtl/pkt_payload_packer.sv
// Long-write packet payload packer top. Wires the sequencer, the byte packer
// and the wait-window timer. Assumes TIMEOUT_CYCLES >= 1 and LANES >= 2.
module pkt_payload_packer
    import ppk_pkg::*;
#(
    parameter int LANES          = 4,
    parameter int TIMEOUT_CYCLES = 50_000_000
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    cmd_valid,
    output logic                    cmd_ready,
    input  logic [BYTE_W-1:0]       cmd_id,
    input  logic [VAL_W-1:0]        cmd_word,
    input  logic                    in_valid,
    output logic                    in_ready,
    input  logic [BYTE_W-1:0]       in_data,
    output logic                    pl_valid,
    input  logic                    pl_ready,
    output logic [LANES*BYTE_W-1:0] pl_data,
    output logic                    hd_valid,
    input  logic                    hd_ready,
    output logic [HDR_W-1:0]        hd_data,
    input  logic                    fifo_empty,
    output logic                    cmp_done,
    output logic                    cmp_timeout
);
    logic pack_start;
    logic pack_last;
    logic wait_run;
    logic wait_expire;

    ppk_ctrl u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_valid   (cmd_valid),
        .cmd_ready   (cmd_ready),
        .cmd_id      (cmd_id),
        .cmd_word    (cmd_word),
        .pack_start  (pack_start),
        .pack_last   (pack_last),
        .hd_valid    (hd_valid),
        .hd_ready    (hd_ready),
        .hd_data     (hd_data),
        .wait_run    (wait_run),
        .wait_expire (wait_expire),
        .fifo_empty  (fifo_empty),
        .cmp_done    (cmp_done),
        .cmp_timeout (cmp_timeout)
    );

    ppk_packer #(.LANES(LANES)) u_packer (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (pack_start),
        .start_count (cmd_word),
        .in_valid    (in_valid),
        .in_ready    (in_ready),
        .in_data     (in_data),
        .out_valid   (pl_valid),
        .out_ready   (pl_ready),
        .out_data    (pl_data),
        .last_taken  (pack_last)
    );

    ppk_timer #(.LIMIT(TIMEOUT_CYCLES)) u_timer (
        .clk    (clk),
        .rst_n  (rst_n),
        .run    (wait_run),
        .expire (wait_expire)
    );

    // R3: header and payload are never offered together.
    p_hdr_after_payload_r3: assert property (@(posedge clk) disable iff (!rst_n)
        hd_valid |-> !pl_valid);

    // R4: no byte is taken while a short write is being handled.
    p_short_no_bytes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (hd_valid || cmd_ready) |-> !in_ready);

endmodule

// File: tb/tb_pkt_payload_packer.sv
`timescale 1ns/1ps
module tb_pkt_payload_packer;

    localparam int TO = 20;
    localparam int NV = 13;

    // Vector fields: id[47:40] value[39:24] seed[23:16] bp[15:12] early[8] delay[7:0]
    localparam logic [47:0] VEC [NV] = '{
        {8'h39, 16'd5,      8'h10, 4'd0, 4'd0, 8'd3},
        {8'h29, 16'd4,      8'h20, 4'd1, 4'd0, 8'd1},
        {8'h39, 16'd1,      8'h30, 4'd0, 4'd0, 8'd2},
        {8'h29, 16'd2,      8'h40, 4'd1, 4'd0, 8'd6},
        {8'h39, 16'd3,      8'h50, 4'd0, 4'd0, 8'd1},
        {8'h39, 16'd0,      8'h60, 4'd0, 4'd0, 8'd2},
        {8'h69, 16'd9,      8'h70, 4'd1, 4'd0, 8'd3},
        {8'h15, 16'hAB51,   8'h00, 4'd1, 4'd0, 8'd255},
        {8'h05, 16'h0029,   8'h00, 4'd0, 4'd0, 8'd255},
        {8'h37, 16'h0010,   8'h00, 4'd0, 4'd0, 8'd255},
        {8'h39, 16'd7,      8'h80, 4'd1, 4'd1, 8'd5},
        {8'h29, 16'd6,      8'h90, 4'd0, 4'd0, 8'd20},
        {8'h39, 16'd8,      8'hA0, 4'd1, 4'd0, 8'd255}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic        cmd_ready;
    logic [7:0]  cmd_id = '0;
    logic [15:0] cmd_word = '0;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_data = '0;
    logic        pl_valid;
    logic        pl_ready = 1'b0;
    logic [31:0] pl_data;
    logic        hd_valid;
    logic        hd_ready = 1'b0;
    logic [31:0] hd_data;
    logic        fifo_empty = 1'b0;
    logic        cmp_done;
    logic        cmp_timeout;

    int n_chk = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    pkt_payload_packer #(.LANES(4), .TIMEOUT_CYCLES(TO)) dut (
        .clk(clk), .rst_n(rst_n),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_id(cmd_id), .cmd_word(cmd_word),
        .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
        .pl_valid(pl_valid), .pl_ready(pl_ready), .pl_data(pl_data),
        .hd_valid(hd_valid), .hd_ready(hd_ready), .hd_data(hd_data),
        .fifo_empty(fifo_empty), .cmp_done(cmp_done), .cmp_timeout(cmp_timeout)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_word(input int cnt, input logic [7:0] seed, input int w);
        logic [31:0] r;
        r = '0;
        for (int k = 0; k < 4; k++) begin
            if (4 * w + k < cnt) r[8*k +: 8] = seed + 8'(4 * w + k);
        end
        return r;
    endfunction

    task automatic run_cmd(input logic [7:0] id, input logic [15:0] val, input logic [7:0] seed,
                           input int bp, input bit early, input int delay);
        bit          is_long;
        int          nbytes, nwords, bi, wi, hk, cyc, exp_hk;
        bit          hdr, fin, prev_stall, short_took, order_bad;
        logic [31:0] prev_pl;
        is_long    = (id[5:0] == 6'h29) || (id[5:0] == 6'h39);
        nbytes     = is_long ? int'(val) : 0;
        nwords     = !is_long ? 0 : (val == 0 ? 1 : (int'(val) + 3) / 4);
        bi = 0; wi = 0; hk = -1; cyc = 0;
        hdr = 0; fin = 0; prev_stall = 0; short_took = 0; order_bad = 0;
        prev_pl = '0;
        exp_hk = !is_long ? 1 : (delay <= TO ? delay + 1 : TO + 1);

        @(negedge clk);
        check(cmd_ready == 1'b1, "R9", "ready while idle", cmd_ready, 1);
        cmd_valid = 1'b1; cmd_id = id; cmd_word = val;
        @(negedge clk);
        cmd_valid = 1'b0;
        check(cmd_ready == 1'b0, "R9", "ready after accept", cmd_ready, 0);

        while (!fin && cyc < 5000) begin
            if (hdr) hk++;
            in_valid   = is_long ? ((bi < nbytes) && (bp == 0 || cyc % 3 != 0)) : 1'b1;
            in_data    = seed + 8'(bi);
            pl_ready   = (bp == 0) || (cyc % 2 == 0);
            hd_ready   = (bp == 0) || (cyc % 4 == 3);
            fifo_empty = hdr ? (hk == delay) : early;
            #1;
            if (!is_long && in_ready) short_took = 1;
            if (in_valid && in_ready) bi++;
            if (prev_stall)
                check(pl_valid && pl_data == prev_pl, "R11", "stalled word held", pl_data, prev_pl);
            if (pl_valid && pl_ready) begin
                check(pl_data == exp_word(nbytes, seed, wi),
                      (4 * wi + 4 > nbytes) ? "R2" : "R1", "payload word",
                      pl_data, exp_word(nbytes, seed, wi));
                wi++;
            end
            if (pl_valid && hdr) order_bad = 1;
            if (hd_valid && !hdr && wi != nwords) order_bad = 1;
            prev_stall = pl_valid && !pl_ready;
            prev_pl    = pl_data;
            if (hd_valid && hd_ready && !hdr) begin
                check(hd_data == {8'h00, val[15:8], val[7:0], id}, is_long ? "R3" : "R4",
                      "header word", hd_data, {8'h00, val[15:8], val[7:0], id});
                check(wi == nwords, "R3", "words before header", wi, nwords);
                hdr = 1; hk = 0;
            end
            if (cmp_done || cmp_timeout) begin
                fin = 1;
                check(!(cmp_done && cmp_timeout), "R8", "exclusive pulses", {cmp_done, cmp_timeout}, 0);
                if (!is_long)
                    check(cmp_done && hk == exp_hk, "R7", "short done cycle", hk, exp_hk);
                else if (delay <= TO)
                    check(cmp_done && hk == exp_hk, early ? "R5" : "R5",
                          "done cycle after fifo-empty", hk, exp_hk);
                else
                    check(cmp_timeout && hk == exp_hk, "R6", "timeout cycle", hk, exp_hk);
            end
            cyc++;
            if (!fin) @(negedge clk);
        end
        check(fin, "R5", "command finished", fin, 1);
        check(!order_bad, "R3", "header only after payload", order_bad, 0);
        if (is_long) check(bi == nbytes, "R2", "bytes consumed", bi, nbytes);
        else         check(!short_took, "R4", "short takes no byte", short_took, 0);
        in_valid = 0; fifo_empty = 0; pl_ready = 0; hd_ready = 0;
        @(negedge clk);
        check(!cmp_done && !cmp_timeout, "R8", "pulse lasts one cycle", {cmp_done, cmp_timeout}, 0);
        check(cmd_ready == 1'b1, "R9", "ready back after end", cmd_ready, 1);
    endtask

    initial begin
        #(200000 * 5);
        n_chk++; n_bad++;
        $display("FAIL watchdog: actual running expected finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        // R10: reset state
        repeat (3) @(negedge clk);
        check(cmd_ready && !in_ready && !pl_valid && !hd_valid && !cmp_done && !cmp_timeout,
              "R10", "reset outputs",
              {cmd_ready, in_ready, pl_valid, hd_valid, cmp_done, cmp_timeout}, 6'b100000);
        rst_n = 1'b1;

        // Table walk
        for (int i = 0; i < NV; i++) begin
            run_cmd(VEC[i][47:40], VEC[i][39:24], VEC[i][23:16],
                    int'(VEC[i][15:12]), VEC[i][8], int'(VEC[i][7:0]));
        end

        // R2 / R3: large count with partial last word and nonzero high count byte
        run_cmd(8'h39, 16'd257, 8'hC0, 1, 1'b0, 4);
        // R6: timeout on a large transfer with a channel tag
        run_cmd(8'hE9, 16'd300, 8'h11, 0, 1'b1, 255);

        // R10: reset in the middle of a packet
        @(negedge clk);
        cmd_valid = 1'b1; cmd_id = 8'h39; cmd_word = 16'd12;
        @(negedge clk);
        cmd_valid = 1'b0; in_valid = 1'b1; in_data = 8'h5A;
        @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        in_valid = 1'b0;
        check(cmd_ready && !in_ready && !pl_valid && !hd_valid && !cmp_done && !cmp_timeout,
              "R10", "mid-packet reset outputs",
              {cmd_ready, in_ready, pl_valid, hd_valid, cmp_done, cmp_timeout}, 6'b100000);
        rst_n = 1'b1;
        run_cmd(8'h29, 16'd10, 8'h33, 0, 1'b0, 2);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

endmodule